// File: doc/BRIEF.md
# Multithread Reset Vector Loader

After reset, this block prepares a set of hardware threads to run. It works through the threads one at a time, in index order. For each thread it fetches a 64-bit start address, one byte at a time, from a vector table held in byte-wide memory. It then commits the thread's architectural start state and pulses that thread's start line.

Thread 0 has its own vector slot. Every other thread has a slot in a second table, one slot after another. Each thread gets a private stack bank number, a stack pointer at the top of its bank, and cleared general registers.

Once the last thread has been started, a done flag rises and stays high. From then on the memory port stays quiet until the next reset.

Top module: `thread_boot_loader`

## Requirements
- R1: Thread 0 reads its vector from addresses 0xFFC0 through 0xFFC7, in ascending order.
- R2: Thread i, for i >= 1, reads its vector from the 8 ascending addresses that begin at 0xFF50 + 8*(i-1).
- R3: The program counter of a thread is assembled little-endian. The byte returned for the lowest vector address becomes bits 7:0, and the byte for the highest address becomes bits 63:56.
- R4: When a thread's start pulse is high, that thread's 16-bit stack pointer reads 0xFFFF.
- R5: When a thread's start pulse is high, that thread's stack bank reads its thread index plus one.
- R6: When a thread's start pulse is high, that thread's A, B, X and Y registers all read zero.
- R7: Threads start in ascending index order. Start pulses are one-hot and last one cycle each. Exactly 8 memory reads (memRd high) occur after the previous start pulse, or after reset for thread 0, and before each thread's start pulse.
- R8: The done flag rises exactly one cycle after the last thread's start pulse and then stays high. No memory read is issued while done is high.
- R9: A synchronous reset (rst high at a clock edge) drives all start pulses and done low. The cycle after rst is released, the loader issues its first read at thread 0, byte 0 (address 0xFFC0), even if reset arrives in the middle of a bring-up.
- R10: Read data is taken from memData one cycle after the cycle in which memRd was high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| memAddr | output | 16 | Byte address of the vector read |
| memRd | output | 1 | Read strobe; data is expected on the next cycle |
| memData | input | 8 | Read data, one cycle after memRd |
| pcOut | output | NUM_THREADS*64 | Per-thread program counters, thread t at [t*64 +: 64] |
| spOut | output | NUM_THREADS*16 | Per-thread stack pointers |
| bankOut | output | NUM_THREADS*8 | Per-thread stack bank numbers |
| aOut | output | NUM_THREADS*64 | Per-thread A registers |
| bOut | output | NUM_THREADS*64 | Per-thread B registers |
| xOut | output | NUM_THREADS*64 | Per-thread X registers |
| yOut | output | NUM_THREADS*64 | Per-thread Y registers |
| startPulse | output | NUM_THREADS | One-cycle start pulse per thread |
| done | output | 1 | High once every thread has been started |

## Verification
The bench builds the loader with NUM_THREADS set to 8, the maximum. This reaches the highest slot of the second table (0xFF80) and uses the full width of the thread index. It also shows that the order holds across every thread boundary.

The memory model returns bytes that depend on the address and on a per-run seed. As a result, a byte swapped into the wrong lane or taken from the wrong address produces a wrong program counter.

A reset asserted after the third start pulse, followed by a second run with a new seed, exercises the restart-from-thread-0 path.

// File: rtl/boot_pkg.sv
package boot_pkg;
  localparam int PC_W       = 64;
  localparam int VEC_BYTES  = PC_W / 8;
  localparam int BYTE_IDX_W = $clog2(VEC_BYTES);
  localparam int THR_IDX_W  = 3;
  localparam int MAX_THREADS = 1 << THR_IDX_W;

  typedef enum logic [2:0] {
    ST_FETCH,
    ST_LAST,
    ST_COMMIT,
    ST_SETTLE,
    ST_FINISHED
  } bootState_t;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic                  rd;
    logic [BYTE_IDX_W-1:0] byteSel;
    logic                  cap;
    logic [BYTE_IDX_W-1:0] capSel;
    logic                  load;
    logic [THR_IDX_W-1:0]  thread;
  } bootStrobe_t;
endpackage

// File: rtl/boot_ctrl.sv
module boot_ctrl
  import boot_pkg::*;
#(
  parameter int NUM_THREADS = 4
) (
  input  logic        clk,
  input  logic        rst,
  output bootStrobe_t strb,
  output logic        done
);
  localparam logic [THR_IDX_W-1:0]  LAST_THR  = THR_IDX_W'(NUM_THREADS - 1);
  localparam logic [BYTE_IDX_W-1:0] LAST_BYTE = BYTE_IDX_W'(VEC_BYTES - 1);

  bootState_t state;
  logic [THR_IDX_W-1:0]  threadIdx;
  logic [BYTE_IDX_W-1:0] byteIdx;
  logic                  capPend;
  logic [BYTE_IDX_W-1:0] capIdx;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_FETCH;
      threadIdx <= '0;
      byteIdx   <= '0;
      capPend   <= 1'b0;
      capIdx    <= '0;
    end else begin
      capPend <= (state == ST_FETCH);
      capIdx  <= byteIdx;
      unique case (state)
        ST_FETCH: begin
          byteIdx <= byteIdx + 1'b1;
          if (byteIdx == LAST_BYTE) state <= ST_LAST;
        end
        ST_LAST:   state <= ST_COMMIT;
        ST_COMMIT: begin
          byteIdx <= '0;
          if (threadIdx == LAST_THR) begin
            state <= ST_SETTLE;
          end else begin
            threadIdx <= threadIdx + 1'b1;
            state     <= ST_FETCH;
          end
        end
        ST_SETTLE:   state <= ST_FINISHED;
        ST_FINISHED: state <= ST_FINISHED;
        default:     state <= ST_FETCH;
      endcase
    end
  end

  always_comb begin
    strb.rd      = (state == ST_FETCH);
    strb.byteSel = byteIdx;
    strb.cap     = capPend;
    strb.capSel  = capIdx;
    strb.load    = (state == ST_COMMIT);
    strb.thread  = threadIdx;
    done         = (state == ST_FINISHED);
  end

  // R7: a commit only follows capture of the final vector byte
  a_r7_load_after_last_byte: assert property (@(posedge clk) disable iff (rst)
    strb.load |-> $past(capPend && capIdx == LAST_BYTE));

  // R9: reset lands on thread 0, byte 0
  a_r9_reset_home: assert property (@(posedge clk)
    $past(rst) |-> (state == ST_FETCH && threadIdx == '0 && byteIdx == '0 && !done));
endmodule

// File: rtl/boot_datapath.sv
module boot_datapath
  import boot_pkg::*;
#(
  parameter int               NUM_THREADS = 4,
  parameter int               ADDR_W      = 16,
  parameter int               SP_W        = 16,
  parameter int               BANK_W      = 8,
  parameter int               GPR_W       = 64,
  parameter logic [ADDR_W-1:0] PRI_BASE   = 16'hFFC0,
  parameter logic [ADDR_W-1:0] SEC_BASE   = 16'hFF50,
  parameter logic [SP_W-1:0]   SP_INIT    = 16'hFFFF
) (
  input  logic                        clk,
  input  logic                        rst,
  input  bootStrobe_t                 strb,
  input  logic [7:0]                  memData,
  output logic [ADDR_W-1:0]           memAddr,
  output logic                        memRd,
  output logic [NUM_THREADS*PC_W-1:0]   pcOut,
  output logic [NUM_THREADS*SP_W-1:0]   spOut,
  output logic [NUM_THREADS*BANK_W-1:0] bankOut,
  output logic [NUM_THREADS*GPR_W-1:0]  aOut,
  output logic [NUM_THREADS*GPR_W-1:0]  bOut,
  output logic [NUM_THREADS*GPR_W-1:0]  xOut,
  output logic [NUM_THREADS*GPR_W-1:0]  yOut,
  output logic [NUM_THREADS-1:0]        startPulse
);
  localparam int SLOT_SHIFT = $clog2(VEC_BYTES);

  logic [PC_W-1:0]   vecBuf;
  logic [ADDR_W-1:0] slotBase;

  // Thread 0 uses the primary slot; others index the secondary table
  always_comb begin
    if (strb.thread == '0)
      slotBase = PRI_BASE;
    else
      slotBase = SEC_BASE + (ADDR_W'(strb.thread - 1'b1) << SLOT_SHIFT);
    memAddr = slotBase + ADDR_W'(strb.byteSel);
    memRd   = strb.rd;
  end

  always_ff @(posedge clk) begin
    if (strb.cap) vecBuf[strb.capSel*8 +: 8] <= memData;
  end

  always_ff @(posedge clk) begin
    if (rst)            startPulse <= '0;
    else if (strb.load) startPulse <= NUM_THREADS'(1) << strb.thread;
    else                startPulse <= '0;
  end

  for (genvar g = 0; g < NUM_THREADS; g++) begin : gThread
    logic [PC_W-1:0]   pcR;
    logic [SP_W-1:0]   spR;
    logic [BANK_W-1:0] bankR;
    logic [GPR_W-1:0]  aR, bR, xR, yR;

    always_ff @(posedge clk) begin
      if (strb.load && strb.thread == THR_IDX_W'(g)) begin
        pcR   <= vecBuf;
        spR   <= SP_INIT;
        bankR <= BANK_W'(g + 1);
        aR    <= '0;
        bR    <= '0;
        xR    <= '0;
        yR    <= '0;
      end
    end

    assign pcOut[g*PC_W +: PC_W]       = pcR;
    assign spOut[g*SP_W +: SP_W]       = spR;
    assign bankOut[g*BANK_W +: BANK_W] = bankR;
    assign aOut[g*GPR_W +: GPR_W]      = aR;
    assign bOut[g*GPR_W +: GPR_W]      = bR;
    assign xOut[g*GPR_W +: GPR_W]      = xR;
    assign yOut[g*GPR_W +: GPR_W]      = yR;

    // R4, R5: stack state seen alongside the start pulse
    a_r4_r5_stack_at_start: assert property (@(posedge clk) disable iff (rst)
      startPulse[g] |-> (spR == SP_INIT && bankR == BANK_W'(g + 1)));
    // R6: general registers are clear at start
    a_r6_gprs_clear: assert property (@(posedge clk) disable iff (rst)
      startPulse[g] |-> (aR == '0 && bR == '0 && xR == '0 && yR == '0));
  end

  // R7: never two threads started at once
  a_r7_onehot_start: assert property (@(posedge clk) disable iff (rst)
    $onehot0(startPulse));
  // R7: a pulse lasts a single cycle
  a_r7_single_cycle: assert property (@(posedge clk) disable iff (rst)
    |startPulse |=> !(|(startPulse & $past(startPulse))));
endmodule

// File: rtl/thread_boot_loader.sv
module thread_boot_loader
  import boot_pkg::*;
#(
  parameter int NUM_THREADS = 4
) (
  input  logic                        clk,
  input  logic                        rst,
  output logic [15:0]                 memAddr,
  output logic                        memRd,
  input  logic [7:0]                  memData,
  output logic [NUM_THREADS*64-1:0]   pcOut,
  output logic [NUM_THREADS*16-1:0]   spOut,
  output logic [NUM_THREADS*8-1:0]    bankOut,
  output logic [NUM_THREADS*64-1:0]   aOut,
  output logic [NUM_THREADS*64-1:0]   bOut,
  output logic [NUM_THREADS*64-1:0]   xOut,
  output logic [NUM_THREADS*64-1:0]   yOut,
  output logic [NUM_THREADS-1:0]      startPulse,
  output logic                        done
);
  bootStrobe_t strb;

  boot_ctrl #(.NUM_THREADS(NUM_THREADS)) u_ctrl (
    .clk  (clk),
    .rst  (rst),
    .strb (strb),
    .done (done)
  );

  boot_datapath #(
    .NUM_THREADS (NUM_THREADS),
    .ADDR_W      (16),
    .SP_W        (16),
    .BANK_W      (8),
    .GPR_W       (64),
    .PRI_BASE    (16'hFFC0),
    .SEC_BASE    (16'hFF50),
    .SP_INIT     (16'hFFFF)
  ) u_dp (
    .clk        (clk),
    .rst        (rst),
    .strb       (strb),
    .memData    (memData),
    .memAddr    (memAddr),
    .memRd      (memRd),
    .pcOut      (pcOut),
    .spOut      (spOut),
    .bankOut    (bankOut),
    .aOut       (aOut),
    .bOut       (bOut),
    .xOut       (xOut),
    .yOut       (yOut),
    .startPulse (startPulse)
  );

  // R8: done rises right after the final thread's pulse
  a_r8_done_after_last_pulse: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $past(startPulse[NUM_THREADS-1]));
  // R8: the memory port is idle once done
  a_r8_quiet_when_done: assert property (@(posedge clk) disable iff (rst)
    done |-> !memRd);
  // R8: done holds
  a_r8_done_sticky: assert property (@(posedge clk) disable iff (rst)
    $past(done) |-> done);
endmodule

// File: tb/thread_boot_loader_tb.sv
module thread_boot_loader_tb;
  localparam int NT = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [15:0] memAddr;
  logic        memRd;
  logic [7:0]  memData = 8'h00;
  logic [NT*64-1:0] pcOut, aOut, bOut, xOut, yOut;
  logic [NT*16-1:0] spOut;
  logic [NT*8-1:0]  bankOut;
  logic [NT-1:0]    startPulse;
  logic             done;

  always #2.5 clk = ~clk;

  thread_boot_loader #(.NUM_THREADS(NT)) u_dut (
    .clk(clk), .rst(rst), .memAddr(memAddr), .memRd(memRd), .memData(memData),
    .pcOut(pcOut), .spOut(spOut), .bankOut(bankOut), .aOut(aOut), .bOut(bOut),
    .xOut(xOut), .yOut(yOut), .startPulse(startPulse), .done(done)
  );

  int checks = 0;
  int fails  = 0;
  int cycle  = 0;
  int pulsesSeen = 0;
  int readsSince = 0;
  int lastPulseCycle = -10;
  logic prevDone = 1'b0;
  logic [7:0] seed = 8'h00;

  logic [15:0] expAddr[$];
  int          expThr[$];
  logic [63:0] expPc[$];

  function automatic logic [7:0] byteAt(logic [15:0] a, logic [7:0] s);
    return ((a[7:0] * 8'd7) + a[15:8] + s) ^ 8'hA5;
  endfunction

  // R10: memory answers one cycle after the read strobe
  always @(posedge clk) if (memRd) memData <= byteAt(memAddr, seed);

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Driver: push the expected reads and thread results for one run
  task automatic loadExpect(input logic [7:0] s);
    expAddr.delete(); expThr.delete(); expPc.delete();
    for (int t = 0; t < NT; t++) begin
      logic [15:0] base;
      logic [63:0] pc;
      base = (t == 0) ? 16'hFFC0 : 16'hFF50 + 16'(8 * (t - 1));
      for (int k = 0; k < 8; k++) begin
        expAddr.push_back(base + 16'(k));
        pc[k*8 +: 8] = byteAt(base + 16'(k), s); // R3 lane order
      end
      expThr.push_back(t);
      expPc.push_back(pc);
    end
  endtask

  // Monitor: compare outputs as they appear, away from the clock edge
  always @(negedge clk) begin
    cycle++;
    if (rst) begin
      check(startPulse == '0, "R9", "pulses during reset", 64'(startPulse), 64'h0);
      check(done == 1'b0, "R9", "done during reset", 64'(done), 64'h0);
      readsSince = 0;
      prevDone = 1'b0;
    end else begin
      if (|startPulse) begin
        int t;
        int et;
        t = -1;
        for (int i = 0; i < NT; i++) if (startPulse[i]) t = i;
        check($countones(startPulse) == 1, "R7", "one-hot pulse", 64'(startPulse), 64'h0);
        check(readsSince == 8, "R7", "reads before pulse", 64'(readsSince), 64'd8);
        if (expThr.size() == 0) begin
          check(1'b0, "R7", "unexpected pulse", 64'(t), 64'h0);
        end else begin
          logic [63:0] ep;
          et = expThr.pop_front();
          ep = expPc.pop_front();
          check(t == et, "R7", "thread order", 64'(t), 64'(et));
          check(pcOut[t*64 +: 64] == ep, (t == 0) ? "R1/R3" : "R2/R3", "program counter",
                pcOut[t*64 +: 64], ep);
          check(spOut[t*16 +: 16] == 16'hFFFF, "R4", "stack pointer",
                64'(spOut[t*16 +: 16]), 64'hFFFF);
          check(bankOut[t*8 +: 8] == 8'(t + 1), "R5", "stack bank",
                64'(bankOut[t*8 +: 8]), 64'(t + 1));
          check((aOut[t*64 +: 64] | bOut[t*64 +: 64] | xOut[t*64 +: 64] | yOut[t*64 +: 64]) == 64'h0,
                "R6", "A/B/X/Y cleared",
                aOut[t*64 +: 64] | bOut[t*64 +: 64] | xOut[t*64 +: 64] | yOut[t*64 +: 64], 64'h0);
        end
        readsSince = 0;
        pulsesSeen++;
        lastPulseCycle = cycle;
      end
      if (memRd) begin
        if (expAddr.size() == 0) begin
          check(1'b0, "R8", "read after all vectors", 64'(memAddr), 64'h0);
        end else begin
          logic [15:0] ea;
          ea = expAddr.pop_front();
          check(memAddr == ea, (ea[7:0] >= 8'hC0) ? "R1" : "R2", "read address",
                64'(memAddr), 64'(ea));
        end
        readsSince++;
        if (done) check(1'b0, "R8", "read while done", 64'(memRd), 64'h0);
      end
      if (done && !prevDone) begin
        check(cycle == lastPulseCycle + 1, "R8", "done latency",
              64'(cycle - lastPulseCycle), 64'd1);
        check(expThr.size() == 0, "R8", "threads left at done", 64'(expThr.size()), 64'h0);
      end
      if (prevDone) check(done == 1'b1, "R8", "done stays high", 64'(done), 64'h1);
      prevDone = done;
    end
  end

  initial begin
    seed = 8'h3C;
    loadExpect(8'h3C);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // Partial bring-up, then reset mid-way (R9)
    wait (pulsesSeen == 3);
    repeat (4) @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    seed = 8'hD1;
    loadExpect(8'hD1);
    @(negedge clk);
    rst = 1'b0;
    wait (done == 1'b1);
    repeat (6) @(negedge clk);
    check(memRd == 1'b0, "R8", "port idle after done", 64'(memRd), 64'h0);
    check(pulsesSeen == 3 + NT, "R7", "total pulses", 64'(pulsesSeen), 64'(3 + NT));
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #100000;
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule